// File: doc/BRIEF.md
# SPI Dummy-Cycle Injector for Raw Command Streams

This block sits between software and the serial shifter of a SPI flash controller while the controller runs in raw pass-through mode. In that mode software writes every byte of a flash command itself: the opcode, the address, and then the data. Fast-read style commands need a run of dummy cycles between address and data. Software cannot time those cycles exactly, so the injector takes them over. It reads the opcode from the first byte written after the chip select goes active. When that opcode needs dummy cycles, the block lets the address bytes through. It then takes the single placeholder byte that software writes after the address and discards it. In its place it sends the full dummy sequence to the shifter.

The number of dummy bytes comes from a per-opcode unit count multiplied by a bytes-per-unit parameter (8 by default). Every dummy byte carries the value on the `dummy_byte` input. The width of the address phase is 3 or 4 bytes, chosen by `addr4`. While the dummy bytes go out, the upstream side is stalled through `in_ready`. After the dummy run, or after any opcode that needs no dummies, snooping stops and every later byte passes through unchanged until the chip select is released and asserted again.

Top module: `spi_dummy_inject`

## Requirements
- R1: After reset, with the chip select inactive and no input, `out_valid` is 0 and `in_ready` follows `out_ready`.
- R2: While `cs_active` is 0, every input byte passes through unchanged, whatever its value, and no dummy bytes are produced.
- R3: If the first byte after `cs_active` rises is 0x03, 0x13, 0x02, 0x12, 0xA2, 0x32 or 0x34, all bytes of that selection pass through unchanged and in order.
- R4: Any first byte not listed in R3, R5, R6 or R7 (for example 0x9F) is treated like R3: no dummies, full pass-through.
- R5: A first byte of 0x0B, 0x3B, 0x6B, 0x3C or 0x6C produces 8 dummy bytes (one unit).
- R6: A first byte of 0xBB, 0x0C or 0xBC produces 16 dummy bytes (two units).
- R7: A first byte of 0xEB or 0xEC produces 32 dummy bytes (four units).
- R8: Every injected byte equals the value of `dummy_byte` at the time it is sent.
- R9: For a dummy-needing opcode, the opcode and the next 3 bytes (`addr4`=0) or 4 bytes (`addr4`=1) are forwarded unchanged. The byte after them is accepted and discarded, and the dummy bytes appear in its place, ahead of any later input byte.
- R10: While dummy bytes are pending, `in_ready` is 0. With `out_ready` held at 1, an upstream byte waits exactly as many cycles as there are dummy bytes.
- R11: Once the dummy run ends, snooping stays off until the next rising edge of `cs_active`. Later bytes, including opcode-like values, pass through unchanged.
- R12: Deasserting `cs_active` during a dummy run ends it at once. `out_valid` then follows `in_valid`, and no leftover dummy byte appears in the next selection.
- R13: Each new rising edge of `cs_active` arms decoding afresh, so back-to-back selections are each decoded from their own first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_active | input | 1 | Flash chip select is asserted |
| addr4 | input | 1 | Address phase is 4 bytes (else 3) |
| dummy_byte | input | 8 | Value sent in each injected dummy byte |
| in_valid | input | 1 | Upstream byte is offered |
| in_data | input | 8 | Upstream byte |
| in_ready | output | 1 | Upstream byte is taken this cycle |
| out_valid | output | 1 | Byte offered to the shifter |
| out_data | output | 8 | Byte to the shifter |
| out_ready | input | 1 | Shifter takes the byte this cycle |

## Verification
The hardest situation to reach from the ports is a chip-select release that lands in the middle of a dummy run, followed by a fresh selection. It needs an exact address-phase length, an accepted placeholder byte, and a deassertion in the very next cycle. A directed case builds this with the shifter always ready. It checks that the dummy stream stops at once and that the next selection shows no leftover dummies. Random selections then mix all opcode classes, unknown opcodes, both address widths, short commands that end before the placeholder, and random shifter back-pressure. Each output stream is compared with a model of the requirements built in the bench.

// File: rtl/snoop_inj_pkg.sv
package snoop_inj_pkg;

  // Snoop tracking state for one chip-select period.
  typedef enum logic [1:0] {
    SN_OFF    = 2'd0,  // pass-through, not decoding
    SN_ARMED  = 2'd1,  // next accepted byte is the opcode
    SN_ADDR   = 2'd2,  // counting address bytes
    SN_INJECT = 2'd3   // emitting dummy bytes
  } snoop_state_e;

endpackage

// File: rtl/snoop_opcode_decode.sv
module snoop_opcode_decode #(
  parameter int UNIT_W = 3
) (
  input  logic [7:0]        opcode,
  output logic [UNIT_W-1:0] units
);

  // Dummy units per opcode; anything unlisted needs none.
  always_comb begin
    case (opcode)
      8'h0B, 8'h3B, 8'h6B, 8'h3C, 8'h6C: units = UNIT_W'(1);
      8'hBB, 8'h0C, 8'hBC:               units = UNIT_W'(2);
      8'hEB, 8'hEC:                      units = UNIT_W'(4);
      default:                           units = '0;
    endcase
  end

endmodule

// File: rtl/snoop_dummy_counter.sv
module snoop_dummy_counter #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (dec && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load || dec) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt  = cnt_q;
  assign last = (cnt_q == CNT_W'(1));

  // R5: a load fixes the remaining dummy count for the next cycle
  a_r5_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));

  // R10: every sent dummy byte lowers the remaining count by one
  a_r10_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/snoop_byte_index.sv
module snoop_byte_index #(
  parameter int IDX_W   = 3,
  parameter int IDX_MAX = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_one,
  input  logic             advance,
  output logic [IDX_W-1:0] idx
);

  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    idx_d = idx_q;
    if (set_one) begin
      idx_d = IDX_W'(1);
    end else if (advance && (idx_q < IDX_W'(IDX_MAX))) begin
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (set_one || advance) begin
      idx_q <= idx_d;
    end
  end

  assign idx = idx_q;

  // R9: the byte index never runs past the trigger position
  a_r9_index_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q <= IDX_W'(IDX_MAX)));

endmodule

// File: rtl/spi_dummy_inject.sv
module spi_dummy_inject #(
  parameter int UNIT_BYTES = 8,
  parameter int MAX_UNITS  = 4,
  parameter int SHORT_ADDR = 3,
  parameter int LONG_ADDR  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_active,
  input  logic       addr4,
  input  logic [7:0] dummy_byte,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  input  logic       out_ready
);

  import snoop_inj_pkg::*;

  localparam int UNIT_W = $clog2(MAX_UNITS + 1);
  localparam int CNT_W  = $clog2(MAX_UNITS * UNIT_BYTES + 1);
  localparam int IDX_W  = $clog2(LONG_ADDR + 2);
  localparam int IDX_MAX = LONG_ADDR + 1;

  snoop_state_e state_q, state_d, cur_state;
  logic         cs_q;
  logic         cs_arm;
  logic         accept;
  logic         trigger;
  logic [UNIT_W-1:0] op_units;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  trig_idx;
  logic              idx_set, idx_adv;
  logic [CNT_W-1:0]  cnt, cnt_load_val;
  logic              cnt_load, cnt_dec, cnt_last;

  snoop_opcode_decode #(.UNIT_W(UNIT_W)) u_decode (
    .opcode (in_data),
    .units  (op_units)
  );

  snoop_byte_index #(.IDX_W(IDX_W), .IDX_MAX(IDX_MAX)) u_index (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_one (idx_set),
    .advance (idx_adv),
    .idx     (idx)
  );

  snoop_dummy_counter #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_load_val),
    .dec      (cnt_dec),
    .cnt      (cnt),
    .last     (cnt_last)
  );

  // Effective state this cycle: a released select forces pass-through,
  // a fresh select arms the opcode decode in the same cycle.
  assign cs_arm = cs_active && !cs_q;

  always_comb begin
    if (!cs_active) begin
      cur_state = SN_OFF;
    end else if (cs_arm) begin
      cur_state = SN_ARMED;
    end else begin
      cur_state = state_q;
    end
  end

  assign trig_idx     = (addr4 ? IDX_W'(LONG_ADDR) : IDX_W'(SHORT_ADDR)) + IDX_W'(1);
  assign trigger      = (cur_state == SN_ADDR) && (idx >= trig_idx);
  assign cnt_load_val = CNT_W'(op_units * UNIT_BYTES);

  // Byte path
  always_comb begin
    out_data  = in_data;
    out_valid = in_valid;
    in_ready  = out_ready;
    if (cur_state == SN_INJECT) begin
      out_data  = dummy_byte;
      out_valid = 1'b1;
      in_ready  = 1'b0;
    end else if (trigger) begin
      out_valid = 1'b0;
      in_ready  = 1'b1;
    end
  end

  assign accept = in_valid && in_ready;

  // Next-state logic
  always_comb begin
    state_d  = cur_state;
    idx_set  = 1'b0;
    idx_adv  = 1'b0;
    cnt_load = 1'b0;
    cnt_dec  = 1'b0;
    case (cur_state)
      SN_ARMED: begin
        if (accept) begin
          if (op_units == '0) begin
            state_d = SN_OFF;
          end else begin
            state_d  = SN_ADDR;
            idx_set  = 1'b1;
            cnt_load = 1'b1;
          end
        end
      end
      SN_ADDR: begin
        if (accept) begin
          if (trigger) begin
            state_d = SN_INJECT;
          end else begin
            idx_adv = 1'b1;
          end
        end
      end
      SN_INJECT: begin
        if (out_ready) begin
          cnt_dec = 1'b1;
          if (cnt_last) begin
            state_d = SN_OFF;
          end
        end
      end
      default: state_d = SN_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SN_OFF;
      cs_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cs_q    <= cs_active;
    end
  end

  // R2: a released chip select leaves the tracker off
  a_r2_off_when_released: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active |=> (state_q == SN_OFF));

  // R10: upstream is stalled for as long as dummies are still owed
  a_r10_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SN_INJECT && cs_active && cs_q) |-> !in_ready);

  // R9: the placeholder byte is taken but never forwarded
  a_r9_swallow: assert property (@(posedge clk) disable iff (!rst_n)
    (trigger && in_valid) |-> (in_ready && !out_valid));

  // R11: after the last dummy byte the tracker stays off
  a_r11_off_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state == SN_INJECT && out_ready && cnt_last) |=> (state_q == SN_OFF));

  // R3: an opcode with no dummies turns snooping off at once
  a_r3_zero_units_off: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state == SN_ARMED && accept && op_units == '0) |=> (state_q == SN_OFF));

  // R8: while injecting, the offered byte follows the dummy value
  a_r8_dummy_value: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SN_INJECT && cs_active && cs_q) |-> (out_valid && out_data == dummy_byte));

endmodule

// File: tb/spi_dummy_inject_tb.sv
module spi_dummy_inject_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs_active;
  logic       addr4;
  logic [7:0] dummy_byte;
  logic       in_valid;
  logic [7:0] in_data;
  logic       in_ready;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_ready;

  int n_tests = 0;
  int n_fail  = 0;
  bit rand_ready = 1'b0;
  bit capture    = 1'b0;
  int stalls     = 0;
  bit done       = 1'b0;

  logic [7:0] tx_q[$];
  logic [7:0] got_q[$];
  logic [7:0] exp_q[$];

  spi_dummy_inject u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_active  (cs_active),
    .addr4      (addr4),
    .dummy_byte (dummy_byte),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_ready  (out_ready)
  );

  always #4 clk = ~clk;  // 125 MHz

  // Shifter back-pressure
  always @(negedge clk) begin
    out_ready = rand_ready ? (($urandom % 4) != 0) : 1'b1;
  end

  // Output and stall monitor, away from the active edge
  always @(negedge clk) begin
    #1;
    if (capture && out_valid && out_ready) got_q.push_back(out_data);
    if (capture && in_valid && !in_ready && out_ready) stalls++;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int units_of(input logic [7:0] op);
    case (op)
      8'h0B, 8'h3B, 8'h6B, 8'h3C, 8'h6C: return 1;
      8'hBB, 8'h0C, 8'hBC:               return 2;
      8'hEB, 8'hEC:                      return 4;
      default:                           return 0;
    endcase
  endfunction

  // Expected shifter stream for tx_q under one selection
  task automatic build_exp(input bit sel, input bit a4, input logic [7:0] dv);
    int u, aw;
    exp_q.delete();
    u  = sel ? units_of(tx_q[0]) : 0;
    aw = a4 ? 4 : 3;
    for (int i = 0; i < tx_q.size(); i++) begin
      if (u == 0 || i <= aw) exp_q.push_back(tx_q[i]);
      else if (i == aw + 1) begin
        for (int k = 0; k < u * 8; k++) exp_q.push_back(dv);
      end else exp_q.push_back(tx_q[i]);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    #2;
    while (!in_ready) begin
      @(negedge clk);
      #2;
    end
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic compare(input string req);
    int bad;
    bad = -1;
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++) begin
      if (bad < 0 && got_q[i] !== exp_q[i]) bad = i;
    end
    if (got_q.size() != exp_q.size())
      check(1'b0, req, "stream length", got_q.size(), exp_q.size());
    else if (bad >= 0)
      check(1'b0, req, $sformatf("byte %0d", bad), got_q[bad], exp_q[bad]);
    else
      check(1'b1, req, "stream", 0, 0);
  endtask

  // One selection: raise select, send tx_q, drain, compare, release
  task automatic run_txn(input bit a4, input logic [7:0] dv, input string req);
    got_q.delete();
    stalls = 0;
    addr4 = a4;
    dummy_byte = dv;
    @(negedge clk);
    cs_active = 1'b1;
    capture = 1'b1;
    foreach (tx_q[i]) send_byte(tx_q[i]);
    build_exp(1'b1, a4, dv);
    for (int w = 0; w < 300 && got_q.size() < exp_q.size(); w++) @(negedge clk);
    repeat (3) @(negedge clk);
    capture = 1'b0;
    compare(req);
    @(negedge clk);
    cs_active = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic fill(input int n, input logic [7:0] op);
    tx_q.delete();
    tx_q.push_back(op);
    for (int i = 1; i < n; i++) tx_q.push_back(8'($urandom));
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1 (run completed)");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  localparam int NPOOL = 18;
  logic [7:0] pool [NPOOL] = '{8'h03, 8'h13, 8'h02, 8'h12, 8'hA2, 8'h32, 8'h34,
                               8'h0B, 8'h3B, 8'h6B, 8'h3C, 8'h6C, 8'hBB, 8'h0C,
                               8'hBC, 8'hEB, 8'hEC, 8'h9F};

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    cs_active = 1'b0;
    addr4 = 1'b0;
    dummy_byte = 8'h00;
    in_valid = 1'b0;
    in_data = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1: reset state
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    check(in_ready == out_ready, "R1", "in_ready follows out_ready", in_ready, out_ready);

    // R3: zero-dummy read
    fill(8, 8'h03);
    run_txn(1'b0, 8'hFF, "R3");
    fill(6, 8'h34);
    run_txn(1'b1, 8'hFF, "R3");

    // R4: unknown opcode
    fill(7, 8'h9F);
    run_txn(1'b0, 8'hFF, "R4");

    // R5 and R10: one unit, exact stall count with shifter always ready
    tx_q = '{8'h0B, 8'h01, 8'h02, 8'h03, 8'h00, 8'hD1, 8'hD2};
    run_txn(1'b0, 8'h5A, "R5");
    check(stalls == 8, "R10", "stall cycles one unit", stalls, 8);

    // R6 and R9: two units with 4-byte address
    tx_q = '{8'hBC, 8'h11, 8'h22, 8'h33, 8'h44, 8'h00, 8'hE1, 8'hE2};
    run_txn(1'b1, 8'h3C, "R6/R9");
    check(stalls == 16, "R10", "stall cycles two units", stalls, 16);

    // R7 and R8: four units with a distinctive dummy value
    tx_q = '{8'hEB, 8'h10, 8'h20, 8'h30, 8'h00, 8'h77};
    run_txn(1'b0, 8'hA5, "R7/R8");
    check(stalls == 32, "R10", "stall cycles four units", stalls, 32);

    // R9: 4-byte opcode with 4-byte address
    tx_q = '{8'h0C, 8'hA0, 8'hA1, 8'hA2, 8'hA3, 8'h00, 8'hB0};
    run_txn(1'b1, 8'h00, "R9");

    // R11: opcode-like bytes after the dummy run pass unchanged
    tx_q = '{8'h3B, 8'h01, 8'h02, 8'h03, 8'h00, 8'h0B, 8'hEB, 8'h01, 8'h02, 8'h03, 8'h04};
    run_txn(1'b0, 8'hC3, "R11");

    // R13: back-to-back selections, each decoded afresh
    tx_q = '{8'h6B, 8'h01, 8'h02, 8'h03, 8'h00, 8'h99};
    run_txn(1'b0, 8'h81, "R13");
    tx_q = '{8'h6C, 8'h01, 8'h02, 8'h03, 8'h04, 8'h00, 8'h98};
    run_txn(1'b1, 8'h82, "R13");

    // R2: select inactive, fast-read opcode passes with no dummies
    tx_q = '{8'h0B, 8'h01, 8'h02, 8'h03, 8'h00, 8'h44};
    got_q.delete();
    dummy_byte = 8'hEE;
    cs_active = 1'b0;
    capture = 1'b1;
    foreach (tx_q[i]) send_byte(tx_q[i]);
    repeat (3) @(negedge clk);
    capture = 1'b0;
    build_exp(1'b0, 1'b0, 8'hEE);
    compare("R2");

    // R12: release select right after the placeholder is taken
    addr4 = 1'b0;
    dummy_byte = 8'h6E;
    @(negedge clk);
    cs_active = 1'b1;
    send_byte(8'h0B);
    send_byte(8'h01);
    send_byte(8'h02);
    send_byte(8'h03);
    send_byte(8'h00);
    @(negedge clk);
    cs_active = 1'b0;
    #1;
    check(out_valid == 1'b0, "R12", "out_valid after abort", out_valid, 0);
    check(in_ready == 1'b1, "R12", "in_ready after abort", in_ready, 1);
    repeat (2) @(negedge clk);
    fill(6, 8'h03);
    run_txn(1'b0, 8'h6E, "R12");

    // Random selections mixing all classes and back-pressure
    for (int t = 0; t < 40; t++) begin
      logic [7:0] op;
      int n;
      rand_ready = t[0];
      op = (($urandom % 5) == 0) ? 8'($urandom) : pool[$urandom % NPOOL];
      n = 1 + ($urandom % 10);
      fill(n, op);
      run_txn(1'($urandom), 8'($urandom), "R5/R6/R7/R9 random");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule